// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block schedules up to 32 transmit slots for a CAN protocol engine. The host stores a message identifier for each slot, then raises request pulses. The block keeps a pending bit and a cancel-finished bit for every slot. It offers one frame at a time to the protocol engine: the pending candidate with the numerically lowest identifier key. When the engine finishes a frame, the block writes an event entry into a small event FIFO. Each entry holds the slot number, a timestamp and the kind of event. The two kinds are a normal send and a send that completed although the host had already asked to cancel it.

The slots are split at a configurable boundary. Slots below the boundary are dedicated buffers. Slots at and above it form one shared region, which works either as a FIFO or as a priority queue. In FIFO mode only one slot of that region, the one at the head, competes in the selection. In queue mode every pending slot of the region competes on identifier. Payload storage, the bit-level protocol and memory arbitration are outside this block.

Top module: `tsched_top`

## Requirements
- R1: After reset no slot is pending and no cancel-finished bit is set. `nxt_valid` is low, the event FIFO is empty (`evt_count` 0, `evt_valid` 0) and `evt_ovf` is 0.
- R2: A `req_mask` bit for a slot that is not pending sets that slot's pending bit at the next clock edge and clears its cancel-finished bit. A request for a slot that is already pending has no effect. A pending bit never becomes set without a request.
- R3: The priority key of a slot is its 29-bit identifier when `id_ext`=1. When `id_ext`=0 the key is the 11-bit identifier shifted left by 18. `nxt_slot` and `nxt_key` name the candidate with the lowest key, and on equal keys the lower slot index wins. `nxt_valid` is low while a frame is in flight and when there is no candidate.
- R4: In FIFO mode only one slot of the shared region is a candidate. That slot is the first pending slot in circular order from the head point. The head point moves on by one slot per cycle while the slot it points at is not pending and some other slot of the region is pending.
- R5: The engine accepts a frame by driving `eng_ready` while `nxt_valid` is high, and the offered slot is then in flight. `eng_done` clears the slot's pending bit and logs a normal event. `eng_abort` with no cancel outstanding keeps the slot pending and makes it a candidate again.
- R6: A cancel of a pending slot that is not in flight clears its pending bit and sets its cancel-finished bit at the next clock edge. A cancel of a slot that is not pending has no effect.
- R7: A cancel of a slot that is in flight does not stop the frame, and the slot stays pending. A later `eng_abort` then clears the pending bit, sets the cancel-finished bit and logs no event. A later `eng_done` clears the pending bit, logs an event with `evt_late`=1 and leaves the cancel-finished bit clear.
- R8: An event entry holds the late flag, the slot and the timestamp. The timestamp is the value of a free-running counter that starts at 0 after reset and adds 1 every cycle, taken in the cycle of `eng_done`. The entry is visible from the next cycle. Entries are read oldest first, and an `evt_pop` pulse removes the entry at the head.
- R9: The event FIFO holds 8 entries. An event that arrives while it holds 8 is dropped, and the held entries and the count stay as they were. `evt_ovf` is then set and stays set until reset.
- R10: Slots whose index is below `cfg_ded_num` are dedicated. The other slots form the shared region, which is a priority queue when `cfg_queue_mode`=1 and a FIFO when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ded_num | input | 6 | Number of dedicated slots (0 to 32) |
| cfg_queue_mode | input | 1 | Shared region mode: 1 = queue, 0 = FIFO |
| id_we | input | 1 | Write the identifier of one slot |
| id_slot | input | 5 | Slot whose identifier is written |
| id_val | input | 29 | Identifier value |
| id_ext | input | 1 | 1 = 29-bit identifier, 0 = 11-bit identifier in bits 10:0 |
| req_mask | input | 32 | One-cycle transmit request, one bit per slot |
| cxl_mask | input | 32 | One-cycle cancel request, one bit per slot |
| pend_o | output | 32 | Pending status, one bit per slot |
| cxl_done_o | output | 32 | Cancel-finished status, one bit per slot |
| nxt_valid | output | 1 | A frame is offered to the engine |
| nxt_slot | output | 5 | Offered slot |
| nxt_key | output | 29 | Priority key of the offered slot |
| eng_ready | input | 1 | Engine takes the offered frame |
| eng_done | input | 1 | The frame in flight completed |
| eng_abort | input | 1 | The frame in flight was not sent (lost or stopped) |
| evt_pop | input | 1 | Remove the oldest event entry |
| evt_valid | output | 1 | Event FIFO not empty |
| evt_late | output | 1 | Oldest entry: 1 = sent despite a cancel |
| evt_slot | output | 5 | Oldest entry: slot |
| evt_ts | output | 16 | Oldest entry: timestamp |
| evt_count | output | 4 | Entries held |
| evt_ovf | output | 1 | Sticky flag: an event was dropped |

## Verification
Selection is tested with a mix of keys. Two extended identifiers are equal, which checks that the lower index wins the tie. A small extended identifier is set next to a standard identifier that is only slightly larger once shifted, which checks the left-shift of standard keys. The shared region is filled with a large key at its head and a small key behind it, once in FIFO mode and once in queue mode. With the same stimulus the two modes must send in opposite orders. Cancels are applied to an idle pending slot, to a slot that is not pending, and to a frame in flight that then either completes or aborts, so that each of the four cancel outcomes gives a different result at the status and event ports.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  localparam int CAN_EXT_W = 29;
  localparam int CAN_STD_W = 11;

  typedef enum logic {EVK_SENT = 1'b0, EVK_LATE = 1'b1} evt_kind_e;

  // Standard identifiers sit in the upper bits so both formats compare in one space.
  function automatic logic [CAN_EXT_W-1:0] prio_key(input logic [CAN_EXT_W-1:0] id,
                                                   input logic ext);
    return ext ? id : {id[CAN_STD_W-1:0], {(CAN_EXT_W-CAN_STD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/tsched_pick.sv
module tsched_pick #(
  parameter int N      = 32,
  parameter int KEY_W  = 29,
  parameter int SLOT_W = 5
) (
  input  logic [N-1:0]      cand,
  input  logic [KEY_W-1:0]  keys [N],
  output logic              any,
  output logic [SLOT_W-1:0] slot,
  output logic [KEY_W-1:0]  key
);
  // Downward scan with <= lets the lower index take a tie.
  always_comb begin
    any  = 1'b0;
    slot = '0;
    key  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!any || keys[i] <= key)) begin
        any  = 1'b1;
        slot = SLOT_W'(i);
        key  = keys[i];
      end
    end
  end
endmodule

// File: rtl/tsched_evq.sv
module tsched_evq #(
  parameter int W     = 22,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count < CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign drop    = push && !push_ok;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (drop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/tsched_top.sv
module tsched_top
  import tsched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int TS_W      = 16,
  parameter int EVT_DEPTH = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int KEY_W    = CAN_EXT_W,
  localparam int EVT_W    = 1 + SLOT_W + TS_W,
  localparam int EVC_W    = $clog2(EVT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_ded_num,
  input  logic                 cfg_queue_mode,
  input  logic                 id_we,
  input  logic [SLOT_W-1:0]    id_slot,
  input  logic [KEY_W-1:0]     id_val,
  input  logic                 id_ext,
  input  logic [NUM_SLOTS-1:0] req_mask,
  input  logic [NUM_SLOTS-1:0] cxl_mask,
  output logic [NUM_SLOTS-1:0] pend_o,
  output logic [NUM_SLOTS-1:0] cxl_done_o,
  output logic                 nxt_valid,
  output logic [SLOT_W-1:0]    nxt_slot,
  output logic [KEY_W-1:0]     nxt_key,
  input  logic                 eng_ready,
  input  logic                 eng_done,
  input  logic                 eng_abort,
  input  logic                 evt_pop,
  output logic                 evt_valid,
  output logic                 evt_late,
  output logic [SLOT_W-1:0]    evt_slot,
  output logic [TS_W-1:0]      evt_ts,
  output logic [EVC_W-1:0]     evt_count,
  output logic                 evt_ovf
);
  // Circular step inside the shared region [lo, NUM_SLOTS-1].
  function automatic logic [CNT_W-1:0] fifo_step(input logic [CNT_W-1:0] g,
                                                input logic [CNT_W-1:0] lo);
    return (g == CNT_W'(NUM_SLOTS - 1)) ? lo : g + 1'b1;
  endfunction

  logic [NUM_SLOTS-1:0] pend_q, cxl_req_q, cxl_done_q;
  logic [KEY_W-1:0]     key_q [NUM_SLOTS];
  logic                 inflight_q;
  logic [SLOT_W-1:0]    busy_q;
  logic [CNT_W-1:0]     get_q, get_eff;
  logic [TS_W-1:0]      ts_q;

  // Named events for the checker.
  logic                 fifo_en, head_pend, fifo_any;
  logic [NUM_SLOTS-1:0] fifo_mask, cand;
  logic                 acc, ev_push, ev_late, ev_drop;
  evt_kind_e            ev_kind;
  logic [EVT_W-1:0]     ev_din, ev_dout;

  assign fifo_en = !cfg_queue_mode && (cfg_ded_num < CNT_W'(NUM_SLOTS));
  assign get_eff = (get_q < cfg_ded_num || get_q >= CNT_W'(NUM_SLOTS)) ? cfg_ded_num : get_q;
  assign head_pend = fifo_en && pend_q[get_eff[SLOT_W-1:0]];
  assign fifo_any  = |(pend_q & fifo_mask);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_region
    assign fifo_mask[i] = fifo_en && (CNT_W'(i) >= cfg_ded_num);
    assign cand[i] = pend_q[i] && !inflight_q &&
                     (!fifo_mask[i] || (CNT_W'(i) == get_eff));
  end

  tsched_pick #(.N(NUM_SLOTS), .KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_pick (
    .cand (cand),
    .keys (key_q),
    .any  (nxt_valid),
    .slot (nxt_slot),
    .key  (nxt_key)
  );

  assign acc     = nxt_valid && eng_ready;
  assign ev_push = eng_done && inflight_q;
  assign ev_late = cxl_req_q[busy_q] | cxl_mask[busy_q];
  assign ev_kind = ev_late ? EVK_LATE : EVK_SENT;
  assign ev_din  = {logic'(ev_kind), busy_q, ts_q};

  always_ff @(posedge clk) begin
    if (id_we) key_q[id_slot] <= prio_key(id_val, id_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      cxl_req_q  <= '0;
      cxl_done_q <= '0;
      inflight_q <= 1'b0;
      busy_q     <= '0;
      get_q      <= '0;
      ts_q       <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (acc) begin
        inflight_q <= 1'b1;
        busy_q     <= nxt_slot;
      end else if (inflight_q && (eng_done || eng_abort)) begin
        inflight_q <= 1'b0;
      end
      if (fifo_en && !head_pend && fifo_any) get_q <= fifo_step(get_eff, cfg_ded_num);
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (inflight_q && busy_q == SLOT_W'(i) && eng_done) begin
          pend_q[i]    <= 1'b0;
          cxl_req_q[i] <= 1'b0;
        end else if (inflight_q && busy_q == SLOT_W'(i) && eng_abort &&
                     (cxl_req_q[i] || cxl_mask[i])) begin
          pend_q[i]     <= 1'b0;
          cxl_req_q[i]  <= 1'b0;
          cxl_done_q[i] <= 1'b1;
        end else if (cxl_mask[i] && pend_q[i]) begin
          if ((inflight_q && busy_q == SLOT_W'(i)) || (acc && nxt_slot == SLOT_W'(i))) begin
            cxl_req_q[i] <= 1'b1;
          end else begin
            pend_q[i]     <= 1'b0;
            cxl_done_q[i] <= 1'b1;
          end
        end else if (req_mask[i] && !pend_q[i]) begin
          pend_q[i]     <= 1'b1;
          cxl_req_q[i]  <= 1'b0;
          cxl_done_q[i] <= 1'b0;
        end
      end
    end
  end

  tsched_evq #(.W(EVT_W), .DEPTH(EVT_DEPTH)) u_evq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .din   (ev_din),
    .pop   (evt_pop),
    .dout  (ev_dout),
    .count (evt_count),
    .ovf   (evt_ovf),
    .drop  (ev_drop)
  );

  assign pend_o     = pend_q;
  assign cxl_done_o = cxl_done_q;
  assign evt_valid  = (evt_count != '0);
  assign evt_late   = ev_dout[EVT_W-1];
  assign evt_slot   = ev_dout[TS_W +: SLOT_W];
  assign evt_ts     = ev_dout[TS_W-1:0];
endmodule

// File: rtl/tsched_chk.sv
module tsched_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5,
  parameter int EVT_DEPTH = 8,
  parameter int EVC_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] req_mask,
  input logic [NUM_SLOTS-1:0] pend_o,
  input logic [NUM_SLOTS-1:0] cxl_done_o,
  input logic                 nxt_valid,
  input logic [SLOT_W-1:0]    nxt_slot,
  input logic                 eng_done,
  input logic                 eng_abort,
  input logic                 inflight_q,
  input logic [SLOT_W-1:0]    busy_q,
  input logic                 ev_late,
  input logic                 ev_drop,
  input logic                 evt_pop,
  input logic [EVC_W-1:0]     evt_count,
  input logic                 evt_ovf
);
  a_r2_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~$past(pend_o) & ~$past(req_mask)) == '0);

  a_r3_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid |-> pend_o[nxt_slot]);

  a_r3_quiet_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !nxt_valid);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && inflight_q) |=> !pend_o[$past(busy_q)]);

  a_r5_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_abort && inflight_q && !ev_late) |=> pend_o[$past(busy_q)]);

  a_r7_flight_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q && !eng_done && !eng_abort) |=> pend_o[$past(busy_q)]);

  a_r6_done_not_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (cxl_done_o & pend_o) == '0);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count <= EVC_W'(EVT_DEPTH));

  a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !evt_pop) |=> evt_count == $past(evt_count));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> evt_ovf);
endmodule

bind tsched_top tsched_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .EVT_DEPTH(EVT_DEPTH), .EVC_W(EVC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_mask(req_mask), .pend_o(pend_o),
  .cxl_done_o(cxl_done_o), .nxt_valid(nxt_valid), .nxt_slot(nxt_slot),
  .eng_done(eng_done), .eng_abort(eng_abort), .inflight_q(inflight_q),
  .busy_q(busy_q), .ev_late(ev_late), .ev_drop(ev_drop), .evt_pop(evt_pop),
  .evt_count(evt_count), .evt_ovf(evt_ovf)
);

// File: tb/sim_tsched_top.sv
module sim_tsched_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_ded_num = 6'd32;
  logic        cfg_queue_mode = 1'b0;
  logic        id_we = 1'b0;
  logic [4:0]  id_slot = '0;
  logic [28:0] id_val = '0;
  logic        id_ext = 1'b0;
  logic [N-1:0] req_mask = '0, cxl_mask = '0;
  logic [N-1:0] pend_o, cxl_done_o;
  logic        nxt_valid;
  logic [4:0]  nxt_slot;
  logic [28:0] nxt_key;
  logic        eng_ready = 1'b0, eng_done = 1'b0, eng_abort = 1'b0, evt_pop = 1'b0;
  logic        evt_valid, evt_late, evt_ovf;
  logic [4:0]  evt_slot;
  logic [15:0] evt_ts;
  logic [3:0]  evt_count;

  tsched_top u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0;
  logic [15:0] bcnt;
  always @(posedge clk) begin
    if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 1'b1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] key_of(input logic [28:0] id, input logic ext);
    return ext ? id : (id << 18);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
    id_we = 0; req_mask = '0; cxl_mask = '0;
    eng_ready = 0; eng_done = 0; eng_abort = 0; evt_pop = 0;
  endtask

  task automatic set_id(input int s, input logic [28:0] id, input logic ext);
    id_we = 1; id_slot = 5'(s); id_val = id; id_ext = ext; tick();
  endtask

  task automatic request(input logic [N-1:0] m); req_mask = m; tick(); endtask
  task automatic cancel(input logic [N-1:0] m);  cxl_mask = m; tick(); endtask

  task automatic accept(input int s, input string tag);
    for (int k = 0; k < 40 && !nxt_valid; k++) tick();
    chk({tag, " offer valid"}, 64'(nxt_valid), 64'd1);
    chk({tag, " offered slot"}, 64'(nxt_slot), 64'(s));
    eng_ready = 1; tick();
  endtask

  task automatic finish_ok(output logic [15:0] ts);
    ts = bcnt; eng_done = 1; tick();
  endtask

  task automatic send(input int s, input string tag, output logic [15:0] ts);
    accept(s, tag); finish_ok(ts);
  endtask

  task automatic pop_check(input int s, input logic late, input logic [15:0] ts, input string tag);
    chk({tag, " evt valid"}, 64'(evt_valid), 64'd1);
    chk({tag, " evt slot"}, 64'(evt_slot), 64'(s));
    chk({tag, " evt late"}, 64'(evt_late), 64'(late));
    chk({tag, " evt ts"}, 64'(evt_ts), 64'(ts));
    evt_pop = 1; tick();
  endtask

  task automatic drain();
    for (int k = 0; k < 16 && evt_valid; k++) begin evt_pop = 1; tick(); end
  endtask

  task automatic t_reset();
    chk("R1 pending", 64'(pend_o), 64'd0);
    chk("R1 cancel done", 64'(cxl_done_o), 64'd0);
    chk("R1 offer", 64'(nxt_valid), 64'd0);
    chk("R1 evt count", 64'(evt_count), 64'd0);
    chk("R1 evt valid", 64'(evt_valid), 64'd0);
    chk("R1 ovf", 64'(evt_ovf), 64'd0);
  endtask

  task automatic t_request();
    logic [15:0] ts;
    set_id(3, 29'h100, 1'b0);
    request(32'h1 << 3);
    chk("R2 pending set", 64'(pend_o), 64'h8);
    chk("R3 std key shifted", 64'(nxt_key), 64'(key_of(29'h100, 1'b0)));
    request(32'h1 << 3);
    tick(); tick();
    chk("R2 re-request no effect", 64'(pend_o), 64'h8);
    send(3, "R2 send", ts);
    chk("R2 pending cleared", 64'(pend_o), 64'd0);
    drain();
  endtask

  task automatic t_priority();
    logic [15:0] ts;
    set_id(2, 29'h7FF, 1'b0);
    set_id(9, 29'h1234, 1'b1);
    set_id(4, 29'h1234, 1'b1);
    set_id(6, 29'h001, 1'b0);
    set_id(7, 29'h3FFFF, 1'b1);
    request((32'h1 << 2) | (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 7) | (32'h1 << 9));
    chk("R3 tie key", 64'(nxt_key), 64'h1234);
    send(4, "R3 tie lower index", ts);
    send(9, "R3 second", ts);
    chk("R3 ext below std key", 64'(nxt_key), 64'h3FFFF);
    send(7, "R3 ext before std", ts);
    send(6, "R3 std small", ts);
    send(2, "R3 last", ts);
    chk("R3 no candidate", 64'(nxt_valid), 64'd0);
    drain();
  endtask

  task automatic t_abort();
    logic [15:0] ts;
    set_id(10, 29'h50, 1'b1);
    request(32'h1 << 10);
    accept(10, "R5 accept");
    chk("R3 no offer in flight", 64'(nxt_valid), 64'd0);
    eng_abort = 1; tick();
    chk("R5 abort keeps pending", 64'(pend_o[10]), 64'd1);
    send(10, "R5 resend", ts);
    chk("R5 done clears", 64'(pend_o[10]), 64'd0);
    pop_check(10, 1'b0, ts, "R5 normal event");
  endtask

  task automatic t_cancel();
    set_id(12, 29'h60, 1'b1);
    request(32'h1 << 12);
    cancel(32'h1 << 12);
    chk("R6 cancel clears pending", 64'(pend_o[12]), 64'd0);
    chk("R6 cancel finished", 64'(cxl_done_o[12]), 64'd1);
    cancel(32'h1 << 13);
    chk("R6 cancel idle ignored", 64'(cxl_done_o), 64'(32'h1 << 12));
    request(32'h1 << 12);
    chk("R2 request clears cancel done", 64'(cxl_done_o[12]), 64'd0);
    cancel(32'h1 << 12);
    chk("R6 events none", 64'(evt_count), 64'd0);
  endtask

  task automatic t_late();
    logic [15:0] ts;
    set_id(14, 29'h20, 1'b1);
    request(32'h1 << 14);
    accept(14, "R7 accept");
    cancel(32'h1 << 14);
    tick();
    chk("R7 in flight stays pending", 64'(pend_o[14]), 64'd1);
    finish_ok(ts);
    chk("R7 done clears", 64'(pend_o[14]), 64'd0);
    chk("R7 no cancel finished", 64'(cxl_done_o[14]), 64'd0);
    pop_check(14, 1'b1, ts, "R7 late event");
    set_id(15, 29'h21, 1'b1);
    request(32'h1 << 15);
    accept(15, "R7 accept2");
    cancel(32'h1 << 15);
    eng_abort = 1; tick();
    chk("R7 abort cancel clears", 64'(pend_o[15]), 64'd0);
    chk("R7 abort cancel finished", 64'(cxl_done_o[15]), 64'd1);
    chk("R7 abort no event", 64'(evt_count), 64'd0);
  endtask

  task automatic t_events();
    logic [15:0] t0, t1, t2;
    set_id(16, 29'h30, 1'b1);
    set_id(17, 29'h31, 1'b1);
    set_id(18, 29'h32, 1'b1);
    request((32'h1 << 16) | (32'h1 << 17) | (32'h1 << 18));
    send(16, "R8 a", t0);
    tick();
    send(17, "R8 b", t1);
    tick(); tick();
    send(18, "R8 c", t2);
    chk("R8 count", 64'(evt_count), 64'd3);
    pop_check(16, 1'b0, t0, "R8 first");
    pop_check(17, 1'b0, t1, "R8 second");
    pop_check(18, 1'b0, t2, "R8 third");
    chk("R8 empty", 64'(evt_valid), 64'd0);
  endtask

  task automatic t_fifo();
    logic [15:0] ts;
    cfg_ded_num = 6'd28; cfg_queue_mode = 1'b0;
    set_id(0, 29'h500, 1'b1);
    set_id(28, 29'h1FFFFFFF, 1'b1);
    set_id(29, 29'h0, 1'b1);
    request((32'h1 << 0) | (32'h1 << 28) | (32'h1 << 29));
    send(0, "R10 dedicated first", ts);
    send(28, "R4 fifo head despite key", ts);
    send(29, "R4 fifo next", ts);
    drain();
    cfg_queue_mode = 1'b1;
    request((32'h1 << 28) | (32'h1 << 29));
    send(29, "R10 queue by key", ts);
    send(28, "R10 queue second", ts);
    drain();
    cfg_ded_num = 6'd32; cfg_queue_mode = 1'b0;
  endtask

  task automatic t_overflow();
    logic [15:0] t0, tx;
    set_id(20, 29'h44, 1'b1);
    for (int k = 0; k < 9; k++) begin
      request(32'h1 << 20);
      send(20, "R9 fill", tx);
      if (k == 0) t0 = tx;
    end
    chk("R9 count full", 64'(evt_count), 64'd8);
    chk("R9 ovf set", 64'(evt_ovf), 64'd1);
    pop_check(20, 1'b0, t0, "R9 oldest kept");
    drain();
    chk("R9 ovf sticky", 64'(evt_ovf), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_request();
    t_priority();
    t_abort();
    t_cancel();
    t_late();
    t_events();
    t_fifo();
    t_overflow();
    report();
    $finish;
  end
endmodule